// File: doc/BRIEF.md
# USB Host Transaction Completion Sequencer

This block runs one USB host transaction at the level of whole packets and reports when it has finished. Software starts a transaction by writing a 3-bit token code. The block then hands each packet of that transaction, one at a time, to an external packet engine. It sends a start pulse with a packet kind and waits for the engine's done pulse. After each done pulse it holds a short J-state idle gap. NRZI coding, bit stuffing, CRC and the line driver all belong to the engine and are outside this block.

A SETUP, IN or OUT transaction is made of three packets in order: a token, a data packet and a handshake. The transaction ends only after the handshake and its idle gap. An SOF transaction is a single frame-number token and ends right after that packet's idle gap.

When a transaction ends, the block sets a sticky completion flag and returns the token field to zero. An interrupt output follows the flag whenever the enable input is high. Software clears the flag by writing one to it.

Top module: `usb_xact_seq`

## Requirements
- R1: After reset, `tok_rd` is 000, `cmp_flag` is 0, `irq` is 0 and `pkt_start` is 0.
- R2: While idle (`tok_rd` = 000), a write of code 001 (SETUP), 010 (IN), 011 (OUT) or 100 (SOF) is accepted. In the next cycle `tok_rd` shows the code and `pkt_start` pulses.
- R3: `pkt_start` is a one-cycle pulse. For codes 001, 010 and 011 the packet kinds come in the order token (`pkt_kind` 00), data (01), handshake (10). Each later start comes JIDLE_CYC+1 cycles after the cycle in which `pkt_done` was seen for the previous packet.
- R4: For codes 001, 010 and 011, `cmp_flag` rises JIDLE_CYC+1 cycles after the handshake's `pkt_done` cycle, and not earlier.
- R5: Code 100 issues exactly one packet, of kind SOF (`pkt_kind` 11). `cmp_flag` rises JIDLE_CYC+1 cycles after that packet's `pkt_done` cycle.
- R6: `tok_rd` returns to 000 in the same cycle that `cmp_flag` rises.
- R7: A token write while a transaction is in progress is ignored. `tok_rd` and the packet sequence are unchanged.
- R8: A write of a reserved code (000, 101, 110, 111) starts nothing, leaves `tok_rd` at 000 and never sets `cmp_flag`.
- R9: `cmp_flag` stays set until `clr_wr` is pulsed, which clears it. If a set and a clear land in the same cycle, the set wins.
- R10: `irq` equals `cmp_flag` AND `irq_en`, combinationally. Raising `irq_en` while the flag is pending asserts `irq` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_wr | input | 1 | Write strobe for the token code |
| tok_wdata | input | 3 | Token code written with `tok_wr` |
| tok_rd | output | 3 | Read-back of the token field; 000 when idle |
| clr_wr | input | 1 | Write-one pulse that clears the completion flag |
| irq_en | input | 1 | Completion interrupt enable |
| pkt_start | output | 1 | One-cycle request to the packet engine |
| pkt_kind | output | 2 | Packet kind: 00 token, 01 data, 10 handshake, 11 SOF |
| pkt_done | input | 1 | Packet engine reports that the packet's EOP has ended |
| cmp_flag | output | 1 | Sticky completion request flag |
| irq | output | 1 | Completion interrupt |

## Verification
The bench covers these corner cases, each with the symptom a faulty design would show:
- The completion point for SOF against the three-packet tokens. A design that ends every transaction after the handshake would hang on SOF. One that ends after the token would raise the flag two packets early.
- The done-to-next-start spacing, with packets of different lengths. A missing or extra J-idle cycle shifts every later event by one cycle.
- A clear that lands exactly on a completion. A clear-priority flag would lose the event.
- Writes made while busy, and writes of reserved codes. A design that accepted them would restart the sequence or issue a packet nobody asked for.

// File: rtl/usb_xact_pkg.sv
package usb_xact_pkg;

    localparam int TOK_W = 3;
    localparam int KIND_W = 2;

    localparam logic [TOK_W-1:0] TOK_NONE  = 3'b000;
    localparam logic [TOK_W-1:0] TOK_SETUP = 3'b001;
    localparam logic [TOK_W-1:0] TOK_IN    = 3'b010;
    localparam logic [TOK_W-1:0] TOK_OUT   = 3'b011;
    localparam logic [TOK_W-1:0] TOK_SOF   = 3'b100;

    typedef enum logic [KIND_W-1:0] {
        PK_TOKEN  = 2'b00,
        PK_DATA   = 2'b01,
        PK_HSHAKE = 2'b10,
        PK_SOF    = 2'b11
    } pkt_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT,
        ST_JIDLE
    } seq_state_e;

endpackage

// File: rtl/usb_tok_decode.sv
module usb_tok_decode
    import usb_xact_pkg::*;
(
    input  logic [TOK_W-1:0] code,
    output logic             valid,
    output logic             is_sof
);

    always_comb begin
        valid  = 1'b0;
        is_sof = 1'b0;
        case (code)
            TOK_SETUP, TOK_IN, TOK_OUT: valid = 1'b1;
            TOK_SOF: begin
                valid  = 1'b1;
                is_sof = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/usb_phase_seq.sv
module usb_phase_seq
    import usb_xact_pkg::*;
#(
    parameter int JIDLE_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_sof,
    input  logic              pkt_done,
    output logic              pkt_start,
    output logic [KIND_W-1:0] pkt_kind,
    output logic              busy,
    output logic              xact_end
);

    localparam int CNT_W = (JIDLE_CYC < 2) ? 1 : $clog2(JIDLE_CYC);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(JIDLE_CYC - 1);

    typedef struct packed {
        seq_state_e st;
        pkt_kind_e  kind;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic end_d;

    always_comb begin
        s_d   = s_q;
        end_d = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (go) begin
                    s_d.st   = ST_LAUNCH;
                    s_d.kind = go_sof ? PK_SOF : PK_TOKEN;
                end
            end
            ST_LAUNCH: s_d.st = ST_WAIT;
            ST_WAIT: begin
                if (pkt_done) begin
                    s_d.st  = ST_JIDLE;
                    s_d.cnt = CNT_LOAD;
                end
            end
            ST_JIDLE: begin
                if (s_q.cnt == '0) begin
                    if (s_q.kind == PK_SOF || s_q.kind == PK_HSHAKE) begin
                        end_d  = 1'b1;
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.st   = ST_LAUNCH;
                        s_d.kind = (s_q.kind == PK_TOKEN) ? PK_DATA : PK_HSHAKE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, kind: PK_TOKEN, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign pkt_start = (s_q.st == ST_LAUNCH);
    assign pkt_kind  = s_q.kind;
    assign busy      = (s_q.st != ST_IDLE);
    assign xact_end  = end_d;

endmodule

// File: rtl/usb_cmp_flag.sv
module usb_cmp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic ie,
    output logic flag,
    output logic irq
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = set | (flag_q & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;
    assign irq  = flag_q & ie;

endmodule

// File: rtl/usb_xact_seq.sv
module usb_xact_seq
    import usb_xact_pkg::*;
#(
    parameter int JIDLE_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_wr,
    input  logic [TOK_W-1:0]  tok_wdata,
    output logic [TOK_W-1:0]  tok_rd,
    input  logic              clr_wr,
    input  logic              irq_en,
    output logic              pkt_start,
    output logic [KIND_W-1:0] pkt_kind,
    input  logic              pkt_done,
    output logic              cmp_flag,
    output logic              irq
);

    logic code_ok, code_sof, busy, xact_end, accept;
    logic [TOK_W-1:0] tok_d, tok_q;

    usb_tok_decode u_dec (
        .code   (tok_wdata),
        .valid  (code_ok),
        .is_sof (code_sof)
    );

    assign accept = tok_wr & code_ok & ~busy;

    usb_phase_seq #(.JIDLE_CYC(JIDLE_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (accept),
        .go_sof    (code_sof),
        .pkt_done  (pkt_done),
        .pkt_start (pkt_start),
        .pkt_kind  (pkt_kind),
        .busy      (busy),
        .xact_end  (xact_end)
    );

    usb_cmp_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (xact_end),
        .clr   (clr_wr),
        .ie    (irq_en),
        .flag  (cmp_flag),
        .irq   (irq)
    );

    always_comb begin
        tok_d = tok_q;
        if (accept) begin
            tok_d = tok_wdata;
        end else if (xact_end) begin
            tok_d = TOK_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tok_q <= TOK_NONE;
        end else begin
            tok_q <= tok_d;
        end
    end

    assign tok_rd = tok_q;

endmodule

// File: rtl/usb_xact_seq_chk.sv
module usb_xact_seq_chk
    import usb_xact_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tok_wr,
    input logic [TOK_W-1:0]  tok_wdata,
    input logic [TOK_W-1:0]  tok_rd,
    input logic              clr_wr,
    input logic              irq_en,
    input logic              pkt_start,
    input logic [KIND_W-1:0] pkt_kind,
    input logic              pkt_done,
    input logic              cmp_flag,
    input logic              irq
);

    logic idle_wr_ok, idle_wr_bad;
    assign idle_wr_ok  = (tok_rd == TOK_NONE) && tok_wr &&
                         (tok_wdata inside {TOK_SETUP, TOK_IN, TOK_OUT});
    assign idle_wr_bad = (tok_rd == TOK_NONE) && tok_wr &&
                         !(tok_wdata inside {TOK_SETUP, TOK_IN, TOK_OUT, TOK_SOF});

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idle_wr_ok |=> pkt_start && pkt_kind == PK_TOKEN && tok_rd == $past(tok_wdata));

    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |=> !pkt_start);

    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |-> tok_rd != TOK_NONE);

    p_sof_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((tok_rd == TOK_NONE) && tok_wr && tok_wdata == TOK_SOF)
            |=> pkt_start && pkt_kind == PK_SOF);

    p_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_flag) |-> tok_rd == TOK_NONE && $past(tok_rd) != TOK_NONE);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_rd != TOK_NONE) |=> (tok_rd == $past(tok_rd)) || (tok_rd == TOK_NONE));

    p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idle_wr_bad |=> tok_rd == TOK_NONE && !pkt_start);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_flag && !clr_wr |=> cmp_flag);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && tok_rd == TOK_NONE |=> !cmp_flag);

    p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (cmp_flag && irq_en));

endmodule

bind usb_xact_seq usb_xact_seq_chk u_chk (.*);

// File: tb/usb_xact_seq_tb.sv
module usb_xact_seq_tb;
    import usb_xact_pkg::*;

    localparam int J = 1;

    typedef struct {
        bit        is_flag;
        logic [1:0] kind;
        int        cyc;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tok_wr = 1'b0, clr_wr = 1'b0, irq_en = 1'b0, pkt_done = 1'b0;
    logic [2:0] tok_wdata = 3'b000;
    logic [2:0] tok_rd;
    logic pkt_start, cmp_flag, irq;
    logic [1:0] pkt_kind;

    int cyc = 0, checks = 0, errors = 0;
    bit flag_prev = 1'b0;
    bit finished = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    usb_xact_seq #(.JIDLE_CYC(J)) u_dut (
        .clk(clk), .rst_n(rst_n), .tok_wr(tok_wr), .tok_wdata(tok_wdata),
        .tok_rd(tok_rd), .clr_wr(clr_wr), .irq_en(irq_en),
        .pkt_start(pkt_start), .pkt_kind(pkt_kind), .pkt_done(pkt_done),
        .cmp_flag(cmp_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input bit f, input logic [1:0] k, input int c);
        exp_t e;
        e.is_flag = f; e.kind = k; e.cyc = c;
        sb.push_back(e);
    endtask

    task automatic pop_cmp(input bit f, input logic [1:0] k);
        exp_t e;
        string req;
        req = f ? "R4" : "R3";
        if (sb.size() == 0) begin
            chk(1'b0, req, f ? "unexpected flag rise cyc" : "unexpected start cyc", cyc, -1);
        end else begin
            e = sb.pop_front();
            chk(e.is_flag == f, req, "event type", int'(f), int'(e.is_flag));
            if (!f) chk(e.kind == k, "R3", "packet kind", int'(k), int'(e.kind));
            chk(e.cyc == cyc, req, "event cycle", cyc, e.cyc);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (pkt_start) pop_cmp(1'b0, pkt_kind);
            if (cmp_flag && !flag_prev) pop_cmp(1'b1, 2'b00);
            flag_prev = cmp_flag;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // driver: one transaction, with packet lengths l0..l2
    task automatic run_xact(input logic [2:0] code, input int l0, input int l1,
                            input int l2, input bit busy_wr, input bit clr_same);
        int lens[3];
        bit sof;
        int n, k, d;
        lens[0] = l0; lens[1] = l1; lens[2] = l2;
        sof = (code == TOK_SOF);
        n = sof ? 1 : 3;
        @(negedge clk);
        k = cyc;
        tok_wr = 1'b1; tok_wdata = code;
        push(1'b0, sof ? PK_SOF : PK_TOKEN, k + 1);
        @(negedge clk);
        tok_wr = 1'b0;
        chk(tok_rd == code, "R2", "tok_rd after write", int'(tok_rd), int'(code));
        for (int p = 0; p < n; p++) begin
            if (busy_wr && p == 0) begin
                tok_wr = 1'b1;
                tok_wdata = (code == TOK_SETUP) ? TOK_IN : TOK_SETUP;
                @(negedge clk);
                tok_wr = 1'b0;
                chk(tok_rd == code, "R7", "tok_rd after busy write", int'(tok_rd), int'(code));
            end
            repeat (lens[p]) @(negedge clk);
            d = cyc;
            pkt_done = 1'b1;
            if (p == n - 1) push(1'b1, 2'b00, d + J + 1);
            else push(1'b0, (p == 0) ? PK_DATA : PK_HSHAKE, d + J + 1);
            @(negedge clk);
            pkt_done = 1'b0;
            if (p == n - 1) begin
                repeat (J - 1) @(negedge clk);
                chk(cmp_flag == 1'b0, sof ? "R5" : "R4", "flag before end",
                    int'(cmp_flag), 0);
                if (clr_same) clr_wr = 1'b1;
                @(negedge clk);
                clr_wr = 1'b0;
                chk(cmp_flag == 1'b1, clr_same ? "R9" : (sof ? "R5" : "R4"),
                    "flag at end", int'(cmp_flag), 1);
                chk(tok_rd == TOK_NONE, "R6", "tok_rd at end", int'(tok_rd), 0);
            end else begin
                repeat (J) @(negedge clk);
            end
        end
    endtask

    task automatic clear_flag();
        @(negedge clk);
        clr_wr = 1'b1;
        @(negedge clk);
        clr_wr = 1'b0;
        chk(cmp_flag == 1'b0, "R9", "flag after clear", int'(cmp_flag), 0);
        chk(irq == 1'b0, "R10", "irq after clear", int'(irq), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tok_rd == 3'b000, "R1", "reset tok_rd", int'(tok_rd), 0);
        chk(cmp_flag == 1'b0, "R1", "reset flag", int'(cmp_flag), 0);
        chk(irq == 1'b0, "R1", "reset irq", int'(irq), 0);
        chk(pkt_start == 1'b0, "R1", "reset pkt_start", int'(pkt_start), 0);

        run_xact(TOK_SETUP, 3, 10, 2, 1'b0, 1'b0);
        chk(irq == 1'b0, "R10", "irq with enable low", int'(irq), 0);
        irq_en = 1'b1;
        #1;
        chk(irq == 1'b1, "R10", "irq on enable rise", int'(irq), 1);
        repeat (2) @(negedge clk);
        chk(cmp_flag == 1'b1, "R9", "flag sticky", int'(cmp_flag), 1);
        clear_flag();

        run_xact(TOK_IN, 1, 5, 1, 1'b1, 1'b0);
        chk(irq == 1'b1, "R10", "irq follows flag", int'(irq), 1);
        clear_flag();

        run_xact(TOK_OUT, 2, 1, 4, 1'b0, 1'b0);
        clear_flag();

        run_xact(TOK_SOF, 4, 0, 0, 1'b0, 1'b0);
        clear_flag();

        run_xact(TOK_SOF, 1, 0, 0, 1'b1, 1'b1);
        clear_flag();

        run_xact(TOK_OUT, 1, 1, 1, 1'b0, 1'b1);
        clear_flag();

        foreach (sb[i]) ;
        for (int c = 0; c < 8; c++) begin
            if (!(c inside {1, 2, 3, 4})) begin
                @(negedge clk);
                tok_wr = 1'b1; tok_wdata = 3'(c);
                @(negedge clk);
                tok_wr = 1'b0;
                repeat (3) @(negedge clk);
                chk(tok_rd == 3'b000, "R8", "tok_rd after reserved", int'(tok_rd), 0);
                chk(cmp_flag == 1'b0, "R8", "flag after reserved", int'(cmp_flag), 0);
            end
        end

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R3", "pending expected events", sb.size(), 0);
        summary();
    end

endmodule